// File: doc/BRIEF.md
# Banked RAM direct-address window

This block sits on the direct-address data port of a small 8-bit core. It maps that port onto a 1 KB on-chip data store. The store is split into a 256-byte core RAM and a separate 768-byte expanded RAM, and both arrays are modelled inside the block. A bank-control special-function register, read and written through a narrow SFR port, can redirect the 64-byte direct window at 40h–7Fh onto any of sixteen 64-byte slices of the 1 KB store. Every other direct address, and every address while the window is switched off, reaches core RAM at its own address.

The bank number does not map linearly. Banks 0–3 select the four quarters of core RAM. Banks 4–15 select the expanded RAM, starting at offset (bank−4)×64. A second SFR holds the upper page byte used by the wide external-style accesses. That byte is only stored here and driven out. Each direct access reports, one clock later, which memory it used and the address inside that memory, together with the read data.

Top module: `bwin_top`

## Requirements
- R1: After reset the bank-control SFR (86h) and the page SFR (85h) both read 00h, so the window starts disabled.
- R2: In the bank-control SFR, bit 7 is the window enable and bits 3:0 are the bank number. Bits 6:4 always read 0 and writes to them are ignored, so writing FFh reads back 8Fh.
- R3: The page SFR at 85h stores all 8 bits written to it, reads them back, and drives them on `xpage`.
- R4: With bit 7 of the bank-control SFR at 0, every direct access goes to core RAM (`acc_xram`=0) at the direct address unchanged.
- R5: Direct addresses 00h–3Fh and 80h–FFh go to core RAM at the same address whatever the bank-control SFR holds.
- R6: With the window enabled and bank 0–3, a direct access to 40h–7Fh goes to core RAM at bank×64 + (address−40h).
- R7: With the window enabled and bank 4–15, a direct access to 40h–7Fh goes to expanded RAM (`acc_xram`=1) at (bank−4)×64 + (address−40h), always below 768.
- R8: With the bank-control SFR at 8Ch, a direct write of 55h to 43h lands at expanded offset 203h and reads back as 55h through the window.
- R9: A bank-control write takes effect from the next clock. A direct access presented in the same cycle as the write uses the old mapping.
- R10: `acc_valid`, `acc_xram`, `acc_addr` and `dir_rdata` describe the access presented one clock earlier. The data comes from the memory that the mapping selected, and back-to-back accesses need no idle cycle.
- R11: SFR reads return data one clock after the address, and any SFR address other than 85h and 86h reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, one clock after `sfr_addr` |
| xpage | output | 8 | Current page SFR value |
| dir_req | input | 1 | Direct access request |
| dir_we | input | 1 | Direct access is a write |
| dir_addr | input | 8 | Direct address |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Read data of the previous cycle's access |
| acc_valid | output | 1 | Previous cycle carried an access |
| acc_xram | output | 1 | Previous access used expanded RAM |
| acc_addr | output | 10 | Address inside the selected memory for the previous access |

## Verification
The bench targets the non-linear bank split. It visits banks 3 and 4 and the top bank 15 at the first, a middle and the last window offset. A design that mapped linearly would send bank 4 to core RAM, and one off by a bank would show a wrong `acc_addr`. It checks that addresses 3Fh and 80h are left alone while the window is enabled, since a loose window decode would remap them. It also writes the bank register in the same cycle as a direct access; a bypass from the write data would remap that access too early. Finally it reads core and expanded RAM back to back. A read-data mux steered by the current mapping, rather than a registered one, returns the other memory's byte.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  typedef enum logic {TGT_CORE = 1'b0, TGT_XRAM = 1'b1} tgt_e;
  localparam logic [7:0] SFR_BANK_DEF = 8'h86;
  localparam logic [7:0] SFR_PAGE_DEF = 8'h85;
endpackage

// File: rtl/bwin_spram.sv
module bwin_spram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first synchronous port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bwin_ctrl_regs.sv
module bwin_ctrl_regs #(
  parameter int DW = 8,
  parameter int SFR_AW = 8,
  parameter int BANK_W = 4,
  parameter logic [SFR_AW-1:0] BANK_SFR = bwin_pkg::SFR_BANK_DEF,
  parameter logic [SFR_AW-1:0] PAGE_SFR = bwin_pkg::SFR_PAGE_DEF,
  localparam int GAP_W = DW - 1 - BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  output logic              win_en,
  output logic [BANK_W-1:0] bank,
  output logic [DW-1:0]     page
);
  logic              win_en_q;
  logic [BANK_W-1:0] bank_q;
  logic [DW-1:0]     page_q;
  logic [DW-1:0]     rd_next;
  logic              unused_gap_bits;

  assign unused_gap_bits = ^sfr_wdata[DW-2:BANK_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en_q <= 1'b0;
      bank_q   <= '0;
      page_q   <= '0;
    end else if (sfr_wr) begin
      if (sfr_addr == BANK_SFR) begin
        win_en_q <= sfr_wdata[DW-1];
        bank_q   <= sfr_wdata[BANK_W-1:0];
      end
      if (sfr_addr == PAGE_SFR) page_q <= sfr_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (sfr_addr == BANK_SFR)      rd_next = {win_en_q, {GAP_W{1'b0}}, bank_q};
    else if (sfr_addr == PAGE_SFR) rd_next = page_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_rdata <= '0;
    else     sfr_rdata <= rd_next;
  end

  assign win_en = win_en_q;
  assign bank   = bank_q;
  assign page   = page_q;

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!win_en_q && bank_q == '0 && page_q == '0));

  p_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sfr_addr) == BANK_SFR) |-> sfr_rdata[DW-2:BANK_W] == '0);

  p_page_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(sfr_wr) && $past(sfr_addr) == PAGE_SFR)) |-> $stable(page_q));
endmodule

// File: rtl/bwin_map.sv
module bwin_map
  import bwin_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WIN_BITS = 6,
  parameter int WIN_IDX  = 1,
  parameter int BANK_W   = 4,
  parameter int CORE_BANKS = 4,
  parameter int PA_W     = 10
) (
  input  logic              win_en,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] dir_addr,
  output tgt_e              tgt,
  output logic [PA_W-1:0]   phys
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic            in_win;
  logic [PA_W-1:0] bank_ext;
  logic [PA_W-1:0] low_ext;

  assign in_win   = (dir_addr[ADDR_W-1:WIN_BITS] == HI_W'(WIN_IDX));
  assign bank_ext = PA_W'(bank);
  assign low_ext  = PA_W'(dir_addr[WIN_BITS-1:0]);

  always_comb begin
    tgt  = TGT_CORE;
    phys = PA_W'(dir_addr);
    if (win_en && in_win) begin
      if (bank_ext < PA_W'(CORE_BANKS)) begin
        phys = (bank_ext << WIN_BITS) | low_ext;
      end else begin
        tgt  = TGT_XRAM;
        phys = ((bank_ext - PA_W'(CORE_BANKS)) << WIN_BITS) | low_ext;
      end
    end
  end
endmodule

// File: rtl/bwin_top.sv
module bwin_top
  import bwin_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ADDR_W     = 8,
  parameter int SFR_AW     = 8,
  parameter int CORE_DEPTH = 256,
  parameter int XRAM_DEPTH = 768,
  parameter int WIN_BITS   = 6,
  parameter int WIN_IDX    = 1,
  parameter int BANK_W     = 4,
  localparam int CORE_AW    = $clog2(CORE_DEPTH),
  localparam int XRAM_AW    = $clog2(XRAM_DEPTH),
  localparam int PA_W       = (XRAM_AW > CORE_AW) ? XRAM_AW : CORE_AW,
  localparam int CORE_BANKS = CORE_DEPTH >> WIN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  output logic [DW-1:0]     xpage,
  input  logic              dir_req,
  input  logic              dir_we,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [DW-1:0]     dir_wdata,
  output logic [DW-1:0]     dir_rdata,
  output logic              acc_valid,
  output logic              acc_xram,
  output logic [PA_W-1:0]   acc_addr
);
  logic              win_en;
  logic [BANK_W-1:0] bank;
  tgt_e              tgt;
  tgt_e              tgt_q;
  logic [PA_W-1:0]   phys;
  logic              core_we, xram_we;
  logic [DW-1:0]     core_rd, xram_rd;

  bwin_ctrl_regs #(.DW(DW), .SFR_AW(SFR_AW), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .win_en(win_en), .bank(bank), .page(xpage)
  );

  bwin_map #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .WIN_IDX(WIN_IDX),
             .BANK_W(BANK_W), .CORE_BANKS(CORE_BANKS), .PA_W(PA_W)) u_map (
    .win_en(win_en), .bank(bank), .dir_addr(dir_addr), .tgt(tgt), .phys(phys)
  );

  assign core_we = dir_req && dir_we && (tgt == TGT_CORE);
  assign xram_we = dir_req && dir_we && (tgt == TGT_XRAM);

  bwin_spram #(.DEPTH(CORE_DEPTH), .DW(DW)) u_core (
    .clk(clk), .we(core_we), .addr(phys[CORE_AW-1:0]),
    .wdata(dir_wdata), .rdata(core_rd)
  );

  bwin_spram #(.DEPTH(XRAM_DEPTH), .DW(DW)) u_xram (
    .clk(clk), .we(xram_we), .addr(phys[XRAM_AW-1:0]),
    .wdata(dir_wdata), .rdata(xram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      tgt_q     <= TGT_CORE;
      acc_addr  <= '0;
    end else begin
      acc_valid <= dir_req;
      tgt_q     <= tgt;
      acc_addr  <= phys;
    end
  end

  assign acc_xram  = (tgt_q == TGT_XRAM);
  assign dir_rdata = acc_xram ? xram_rd : core_rd;

  p_valid_lat_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_valid == $past(dir_req));

  p_disabled_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_req) && !$past(win_en))
      |-> (!acc_xram && acc_addr == PA_W'($past(dir_addr))));

  p_outside_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dir_req) &&
     $past(dir_addr[ADDR_W-1:WIN_BITS]) != (ADDR_W-WIN_BITS)'(WIN_IDX))
      |-> (!acc_xram && acc_addr == PA_W'($past(dir_addr))));

  p_xram_range_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_xram) |-> acc_addr < PA_W'(XRAM_DEPTH));
endmodule

// File: tb/tb_bwin_top.sv
module tb_bwin_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = '0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata, xpage;
  logic       dir_req = 1'b0, dir_we = 1'b0;
  logic [7:0] dir_addr = '0, dir_wdata = '0;
  logic [7:0] dir_rdata;
  logic       acc_valid, acc_xram;
  logic [9:0] acc_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] core_m [256];
  bit         core_v [256];
  logic [7:0] x_m [768];
  bit         x_v [768];
  logic [7:0] bank_model = 8'h00;
  logic [7:0] page_model = 8'h00;

  bwin_top dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .xpage(xpage),
    .dir_req(dir_req), .dir_we(dir_we), .dir_addr(dir_addr),
    .dir_wdata(dir_wdata), .dir_rdata(dir_rdata), .acc_valid(acc_valid),
    .acc_xram(acc_xram), .acc_addr(acc_addr)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // mapping written from the requirements
  task automatic expmap(input logic [7:0] breg, input logic [7:0] a,
                        output bit x, output logic [9:0] pa);
    int b;
    b = int'(breg[3:0]);
    x = 1'b0;
    pa = {2'b00, a};
    if (breg[7] && a >= 8'h40 && a <= 8'h7F) begin
      if (b < 4) pa = 10'(b * 64 + int'(a[5:0]));
      else begin
        x = 1'b1;
        pa = 10'((b - 4) * 64 + int'(a[5:0]));
      end
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
    if (a == 8'h86) bank_model = {d[7], 3'b000, d[3:0]};
    if (a == 8'h85) page_model = d;
  endtask

  task automatic sfr_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    sfr_addr = a;
    @(negedge clk);
    chk(req, $sformatf("sfr %0h read", a), int'(sfr_rdata), int'(exp));
  endtask

  task automatic model_update(input bit x, input logic [9:0] pa, input logic [7:0] d);
    if (x) begin x_m[pa] = d; x_v[pa] = 1'b1; end
    else begin core_m[pa[7:0]] = d; core_v[pa[7:0]] = 1'b1; end
  endtask

  task automatic dir_access(input bit we, input logic [7:0] a, input logic [7:0] d,
                            input string req);
    bit x; logic [9:0] pa;
    @(negedge clk);
    dir_req = 1'b1; dir_we = we; dir_addr = a; dir_wdata = d;
    expmap(bank_model, a, x, pa);
    @(negedge clk);
    dir_req = 1'b0; dir_we = 1'b0;
    chk(req, "acc_valid", int'(acc_valid), 1);
    chk(req, $sformatf("acc_xram for %0h", a), int'(acc_xram), int'(x));
    chk(req, $sformatf("acc_addr for %0h", a), int'(acc_addr), int'(pa));
    if (we) model_update(x, pa, d);
    else if (x ? x_v[pa] : core_v[pa[7:0]])
      chk(req, $sformatf("rdata for %0h", a), int'(dir_rdata),
          int'(x ? x_m[pa] : core_m[pa[7:0]]));
  endtask

  task automatic t_reset;
    chk("R1", "acc_valid after reset", int'(acc_valid), 0);
    sfr_read(8'h86, 8'h00, "R1");
    sfr_read(8'h85, 8'h00, "R1");
    chk("R1", "xpage after reset", int'(xpage), 0);
  endtask

  task automatic t_page_and_misc;
    sfr_write(8'h85, 8'hA5);
    sfr_read(8'h85, 8'hA5, "R3");
    chk("R3", "xpage", int'(xpage), int'(page_model));
    sfr_read(8'h90, 8'h00, "R11");
    sfr_read(8'h84, 8'h00, "R11");
  endtask

  task automatic t_bank_bits;
    sfr_write(8'h86, 8'hFF);
    sfr_read(8'h86, 8'h8F, "R2");
    sfr_write(8'h86, 8'h0F);
    sfr_read(8'h86, 8'h0F, "R2");
    dir_access(1'b1, 8'h45, 8'h11, "R4");
    dir_access(1'b0, 8'h45, 8'h00, "R4");
  endtask

  task automatic t_all_banks;
    for (int b = 0; b < 16; b++) begin
      sfr_write(8'h86, 8'(8'h80 | b));
      for (int k = 0; k < 3; k++) begin
        int off;
        off = (k == 0) ? 0 : (k == 1) ? 3 : 63;
        dir_access(1'b1, 8'(8'h40 + off), 8'(b * 16 + off + 8'h21),
                   (b < 4) ? "R6" : "R7");
      end
    end
    for (int b = 15; b >= 0; b--) begin
      sfr_write(8'h86, 8'(8'h80 | b));
      dir_access(1'b0, 8'h40, 8'h00, (b < 4) ? "R6" : "R7");
      dir_access(1'b0, 8'h7F, 8'h00, (b < 4) ? "R6" : "R7");
    end
    sfr_write(8'h86, 8'h03);
    dir_access(1'b0, 8'h00, 8'h00, "R4");
    dir_access(1'b0, 8'hFF, 8'h00, "R4");
  endtask

  task automatic t_example;
    sfr_write(8'h86, 8'h8C);
    dir_access(1'b1, 8'h43, 8'h55, "R8");
    chk("R8", "model offset 203h", int'(x_m[10'h203]), 8'h55);
    dir_access(1'b0, 8'h43, 8'h00, "R8");
    chk("R8", "window read 43h", int'(dir_rdata), 8'h55);
  endtask

  task automatic t_outside;
    sfr_write(8'h86, 8'h85);
    dir_access(1'b1, 8'h3F, 8'h77, "R5");
    dir_access(1'b1, 8'h80, 8'h78, "R5");
    dir_access(1'b0, 8'h3F, 8'h00, "R5");
    dir_access(1'b0, 8'h80, 8'h00, "R5");
    dir_access(1'b0, 8'hC0, 8'h00, "R5");
  endtask

  task automatic t_same_cycle;
    bit x; logic [9:0] pa;
    sfr_write(8'h86, 8'h00);
    dir_access(1'b1, 8'h50, 8'h3C, "R9");
    @(negedge clk);
    sfr_addr = 8'h86; sfr_wdata = 8'h84; sfr_wr = 1'b1;
    dir_req = 1'b1; dir_we = 1'b0; dir_addr = 8'h50;
    @(negedge clk);
    sfr_wr = 1'b0; dir_req = 1'b0;
    chk("R9", "same-cycle access xram", int'(acc_xram), 0);
    chk("R9", "same-cycle access addr", int'(acc_addr), 10'h050);
    chk("R9", "same-cycle access data", int'(dir_rdata), 8'h3C);
    bank_model = 8'h84;
    expmap(bank_model, 8'h50, x, pa);
    chk("R9", "expected remap next", int'(x), 1);
    dir_access(1'b0, 8'h50, 8'h00, "R9");
  endtask

  task automatic t_back_to_back;
    logic [7:0] seq [4];
    bit x; logic [9:0] pa;
    bit px; logic [9:0] ppa;
    sfr_write(8'h86, 8'h8F);
    seq[0] = 8'h40; seq[1] = 8'h3F; seq[2] = 8'h7F; seq[3] = 8'h80;
    px = 1'b0; ppa = '0;
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R10", "burst valid", int'(acc_valid), 1);
        chk("R10", "burst xram", int'(acc_xram), int'(px));
        chk("R10", "burst addr", int'(acc_addr), int'(ppa));
        chk("R10", "burst data", int'(dir_rdata), int'(px ? x_m[ppa] : core_m[ppa[7:0]]));
      end
      if (i < 4) begin
        dir_req = 1'b1; dir_we = 1'b0; dir_addr = seq[i];
        expmap(bank_model, seq[i], x, pa);
        px = x; ppa = pa;
      end else dir_req = 1'b0;
    end
    @(negedge clk);
    chk("R10", "valid drops", int'(acc_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) core_v[i] = 1'b0;
    for (int i = 0; i < 768; i++) x_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_page_and_misc();
    t_bank_bits();
    t_all_banks();
    t_example();
    t_outside();
    t_same_cycle();
    t_back_to_back();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule